// File: doc/BRIEF.md
# I2C Target Address and Bus-Status Front End

This block sits between the two wires of an I2C bus and the control logic of a target (slave) device. It synchronizes SCL and SDA, recognizes START, repeated START and STOP conditions, counts completed clock pulses since the most recent START, and shifts in the first byte after each START so that it can be compared with a programmable own-address byte. The compare covers a 7-bit address, the general-call address and the first (header) byte of a 10-bit address. The second byte of a 10-bit address and the payload shift register sit outside this block.

When the address byte matches, the block raises an address/stop event flag, records the transfer direction and pulls SDA low for the acknowledge clock. After every completed data byte it raises a data event flag. While either flag stands for a transfer in progress it stretches the clock by holding SCL low. When software clears the flag, the block applies the acknowledge value for a master write, or starts shifting out the byte presented on `tx_byte` for a master read. The block also keeps sticky status for a drive collision and for a bus error, plus the last acknowledge received from the master and the reason the address/stop flag was raised.

Top module: `i2c_tgt_front`

## Requirements
- R1: When the first byte after a START has bits [7:1] equal to own-address bits [7:1] (own bits [7:1] nonzero), `as_flag` becomes 1 with `as_cause`=1, and `dir` takes bit 0 of that byte (1 = master reads, 0 = master writes).
- R2: A first byte that does not match raises no flag, and SDA is never driven by the block until the next START. The acknowledge clock therefore reads high.
- R3: With own-address bit 0 set to 1, the byte 0x00 is a match (general call). With bit 0 cleared, 0x00 does not match.
- R4: When own-address bits [7:3] are 11110, a header byte whose bits [7:1] equal own bits [7:1] (bits [2:1] acting as address bits 9:8) matches and sets `hdr10`=1. A header with different bits [2:1] does not match. A plain 7-bit match leaves `hdr10`=0.
- R5: After an address match the block pulls SDA low through the ninth clock and releases it after that clock's falling edge.
- R6: `scl_drive_low` and `clock_hold` are 1 exactly while `data_flag` is set, or while `as_flag` is set with `as_cause`=1. Clearing the flag releases SCL.
- R7: In a master write, `data_flag` rises after the eighth bit of each data byte, and SDA stays released. On `data_flag_clr` the block drives the acknowledge clock with `rsp_nack` (0 pulls SDA low, 1 leaves it high).
- R8: In a master read, `data_flag` rises after the address acknowledge and after each data byte acknowledged by the master (ACK). On `data_flag_clr` the block places `tx_byte` on SDA MSB first. `rx_ack` stores the master's acknowledge bit (0 = ACK, 1 = NACK). A NACK ends the read without raising `data_flag`.
- R9: A STOP after a matched address raises `as_flag` with `as_cause`=0 and does not hold SCL. A STOP in a transfer that was never addressed raises nothing.
- R10: If the block leaves SDA high for a data 1 or a NACK and samples SDA low on the rising SCL edge, `collision` is set and the block stops pulling SDA low until the next START.
- R11: `collision` clears on `coll_clr` and on any START or repeated START.
- R12: A STOP or repeated START inside a transfer, while the number of completed clock pulses since the last START is not a multiple of nine, sets `bus_err`. `bus_err` holds until `berr_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| own_addr_we | input | 1 | Write strobe for the own-address byte |
| own_addr_wdata | input | 8 | New own-address byte; bit 0 enables general call |
| own_addr | output | 8 | Current own-address byte |
| tx_byte | input | 8 | Byte to send in a master read; hold stable for the byte |
| rsp_nack | input | 1 | Acknowledge value to give for a written data byte |
| as_flag_clr | input | 1 | Clears `as_flag` |
| data_flag_clr | input | 1 | Clears `data_flag` and releases the pending bus action |
| coll_clr | input | 1 | Clears `collision` |
| berr_clr | input | 1 | Clears `bus_err` |
| as_flag | output | 1 | Address-match or stop event flag |
| as_cause | output | 1 | 1: last `as_flag` from an address match; 0: from a STOP |
| data_flag | output | 1 | Data byte event flag |
| clock_hold | output | 1 | Status copy of the SCL hold |
| dir | output | 1 | R/W bit of the last matched address byte |
| rx_ack | output | 1 | Last acknowledge bit from the master |
| collision | output | 1 | Sticky drive-collision status |
| bus_err | output | 1 | Sticky bus-error status |
| hdr10 | output | 1 | Last match was a 10-bit header |

## Verification
The address compare is tried with a matching 7-bit byte in both directions, a byte that differs only in the address bits, the general-call byte with recognition on and off, and 10-bit headers whose upper address bits agree or disagree. Together these separate a correct compare from one that ignores the R/W bit, the enable bit or the header bits. Framing is exercised with STOPs and repeated STARTs after whole bytes and after three and five bits, which tells the modulo-nine count apart from a plain edge count. Read transfers drive patterns with mixed ones and zeros and are acknowledged or refused. A master that pulls SDA low against a released bit shows whether later zero bits stay off the wire.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W   = 8;
  localparam int SLOTS    = BYTE_W + 1;
  localparam int CNT_W    = $clog2(SLOTS);

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WR   = 2'd2,
    PH_RD   = 2'd3
  } phase_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic rise,
  output logic fall,
  output logic start,
  output logic stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign rise  = scl & ~scl_p;
  assign fall  = ~scl & scl_p;
  assign start = scl & scl_p & sda_p & ~sda;
  assign stop  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] own,
  input  logic [BYTE_W-1:0] rx,
  output logic              hit,
  output logic              is_hdr10
);
  logic gc_hit, ad_hit, hdr_mode;

  always_comb begin
    gc_hit   = own[0] && (rx == '0);
    ad_hit   = (own[BYTE_W-1:1] != '0) && (rx[BYTE_W-1:1] == own[BYTE_W-1:1]);
    hdr_mode = (own[BYTE_W-1:BYTE_W-5] == 5'b11110);
    hit      = gc_hit | ad_hit;
    is_hdr10 = ad_hit & hdr_mode;
  end
endmodule

// File: rtl/i2c_tgt_front.sv
module i2c_tgt_front
  import i2c_tgt_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ADDR_RST    = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       own_addr_we,
  input  logic [7:0] own_addr_wdata,
  output logic [7:0] own_addr,
  input  logic [7:0] tx_byte,
  input  logic       rsp_nack,
  input  logic       as_flag_clr,
  input  logic       data_flag_clr,
  input  logic       coll_clr,
  input  logic       berr_clr,
  output logic       as_flag,
  output logic       as_cause,
  output logic       data_flag,
  output logic       clock_hold,
  output logic       dir,
  output logic       rx_ack,
  output logic       collision,
  output logic       bus_err,
  output logic       hdr10
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [2:0]       RD_TOP    = 3'(BYTE_W - 2);

  logic [1:0] sync_q;
  logic scl_s, sda_s;
  logic ev_rise, ev_fall, ev_start, ev_stop;

  i2c_tgt_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2c_tgt_cond u_cond (
    .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
    .rise(ev_rise), .fall(ev_fall), .start(ev_start), .stop(ev_stop)
  );

  // bus-side state
  phase_t             phase;
  logic [CNT_W-1:0]   bitpos;
  logic               pend, samp;
  logic [BYTE_W-1:0]  shreg, rx_next;
  logic               drv, rel1, lock, arm;
  logic               in_xfer, addressed;
  logic               hit, hit10;
  logic [2:0]         rd_idx;

  assign rx_next = {shreg[BYTE_W-2:0], samp};
  assign rd_idx  = RD_TOP - bitpos[2:0];

  i2c_tgt_match #(.BYTE_W(BYTE_W)) u_match (
    .own(own_addr), .rx(rx_next), .hit(hit), .is_hdr10(hit10)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr  <= ADDR_RST;
      phase     <= PH_IDLE;
      bitpos    <= '0;
      pend      <= 1'b0;
      samp      <= 1'b1;
      shreg     <= '0;
      drv       <= 1'b0;
      rel1      <= 1'b0;
      lock      <= 1'b0;
      arm       <= 1'b0;
      in_xfer   <= 1'b0;
      addressed <= 1'b0;
      as_flag   <= 1'b0;
      as_cause  <= 1'b0;
      data_flag <= 1'b0;
      dir       <= 1'b0;
      rx_ack    <= 1'b0;
      collision <= 1'b0;
      bus_err   <= 1'b0;
      hdr10     <= 1'b0;
    end else begin
      if (own_addr_we) own_addr <= own_addr_wdata;
      if (as_flag_clr) as_flag <= 1'b0;
      if (coll_clr)    collision <= 1'b0;
      if (berr_clr)    bus_err <= 1'b0;

      // software response releases the stalled bus action
      if (data_flag_clr) begin
        data_flag <= 1'b0;
        if (arm) begin
          arm <= 1'b0;
          if (phase == PH_RD) begin
            drv  <= ~tx_byte[BYTE_W-1] & ~lock;
            rel1 <=  tx_byte[BYTE_W-1] & ~lock;
          end else begin
            drv  <= ~rsp_nack & ~lock;
            rel1 <=  rsp_nack & ~lock;
          end
        end
      end

      // sample on SCL rising edge; released-high check
      if (ev_rise) begin
        pend <= 1'b1;
        samp <= sda_s;
        if (rel1 && !sda_s) begin
          collision <= 1'b1;
          lock      <= 1'b1;
          drv       <= 1'b0;
          rel1      <= 1'b0;
        end
      end

      // a clock pulse completes on the falling edge
      if (ev_fall && pend) begin
        pend   <= 1'b0;
        bitpos <= (bitpos == LAST_SLOT) ? '0 : bitpos + 1'b1;
        unique case (phase)
          PH_ADDR: begin
            if (bitpos != LAST_SLOT) shreg <= rx_next;
            if (bitpos == LAST_BIT) begin
              if (hit) begin
                as_flag   <= 1'b1;
                as_cause  <= 1'b1;
                dir       <= rx_next[0];
                hdr10     <= hit10;
                addressed <= 1'b1;
                drv       <= ~lock;
                rel1      <= 1'b0;
              end else begin
                phase <= PH_IDLE;
              end
            end else if (bitpos == LAST_SLOT) begin
              drv <= 1'b0;
              if (dir) begin
                phase     <= PH_RD;
                data_flag <= 1'b1;
                arm       <= 1'b1;
              end else begin
                phase <= PH_WR;
              end
            end
          end
          PH_WR: begin
            if (bitpos == LAST_BIT) begin
              data_flag <= 1'b1;
              arm       <= 1'b1;
            end else if (bitpos == LAST_SLOT) begin
              drv  <= 1'b0;
              rel1 <= 1'b0;
            end
          end
          PH_RD: begin
            if (bitpos < LAST_BIT) begin
              drv  <= ~tx_byte[rd_idx] & ~lock;
              rel1 <=  tx_byte[rd_idx] & ~lock;
            end else if (bitpos == LAST_BIT) begin
              drv  <= 1'b0;
              rel1 <= 1'b0;
            end else begin
              rx_ack <= samp;
              if (samp) begin
                phase <= PH_IDLE;
              end else begin
                data_flag <= 1'b1;
                arm       <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end

      if (ev_start) begin
        if (in_xfer && bitpos != '0) bus_err <= 1'b1;
        in_xfer   <= 1'b1;
        bitpos    <= '0;
        pend      <= 1'b0;
        phase     <= PH_ADDR;
        collision <= 1'b0;
        lock      <= 1'b0;
        drv       <= 1'b0;
        rel1      <= 1'b0;
        arm       <= 1'b0;
        addressed <= 1'b0;
      end

      if (ev_stop) begin
        if (in_xfer && bitpos != '0) bus_err <= 1'b1;
        in_xfer   <= 1'b0;
        bitpos    <= '0;
        pend      <= 1'b0;
        phase     <= PH_IDLE;
        drv       <= 1'b0;
        rel1      <= 1'b0;
        arm       <= 1'b0;
        addressed <= 1'b0;
        if (addressed) begin
          as_flag  <= 1'b1;
          as_cause <= 1'b0;
        end
      end
    end
  end

  assign sda_drive_low = drv;
  assign scl_drive_low = data_flag | (as_flag & as_cause);
  assign clock_hold    = scl_drive_low;
endmodule

// File: rtl/i2c_tgt_front_chk.sv
module i2c_tgt_front_chk (
  input logic clk,
  input logic rst,
  input logic as_flag,
  input logic as_cause,
  input logic data_flag,
  input logic sda_drive_low,
  input logic collision,
  input logic bus_err,
  input logic berr_clr
);
  // R10
  coll_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    collision |-> !sda_drive_low);

  // R12
  berr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_err) |-> $past(berr_clr));

  // R5
  addr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(as_flag) && as_cause) |-> sda_drive_low);

  // R7
  data_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_flag) |-> !sda_drive_low);
endmodule

bind i2c_tgt_front i2c_tgt_front_chk u_chk (.*);

// File: tb/i2c_tgt_front_test.sv
module i2c_tgt_front_test;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_in, sda_in, scl_drive_low, sda_drive_low;
  logic own_addr_we = 1'b0;
  logic [7:0] own_addr_wdata = 8'h00, own_addr, tx_byte = 8'h00;
  logic rsp_nack = 1'b0, as_flag_clr = 1'b0, data_flag_clr = 1'b0;
  logic coll_clr = 1'b0, berr_clr = 1'b0;
  logic as_flag, as_cause, data_flag, clock_hold, dir, rx_ack;
  logic collision, bus_err, hdr10;

  assign scl_in = m_scl & ~scl_drive_low;
  assign sda_in = m_sda & ~sda_drive_low;

  i2c_tgt_front uut (.*);

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [7:0] v);
    own_addr_wdata = v; own_addr_we = 1'b1; tick(1); own_addr_we = 1'b0; tick(1);
  endtask
  task automatic clr_as();   as_flag_clr = 1'b1;   tick(1); as_flag_clr = 1'b0;   tick(2); endtask
  task automatic clr_data(); data_flag_clr = 1'b1; tick(1); data_flag_clr = 1'b0; tick(2); endtask
  task automatic clr_coll(); coll_clr = 1'b1;      tick(1); coll_clr = 1'b0;      tick(2); endtask
  task automatic clr_berr(); berr_clr = 1'b1;      tick(1); berr_clr = 1'b0;      tick(2); endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP); m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP); m_scl = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP); m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; tick(HP);
    m_scl = 1'b1;
    while (!scl_in) tick(1);
    tick(HP);
    s = sda_in;
    m_scl = 1'b0; tick(HP);
  endtask

  task automatic byte_out(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
  endtask

  task automatic byte_in(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
  endtask

  task automatic t_reset();
    chk("R6 reset scl hold", scl_drive_low, 0);
    chk("R5 reset sda drive", sda_drive_low, 0);
    chk("R1 reset as_flag", as_flag, 0);
    chk("R12 reset bus_err", bus_err, 0);
    chk("R10 reset collision", collision, 0);
  endtask

  task automatic t_write();
    logic s;
    set_addr(8'hA0);
    bus_start();
    byte_out(8'hA0);
    tick(2);
    chk("R1 as_flag", as_flag, 1);
    chk("R1 as_cause", as_cause, 1);
    chk("R1 dir write", dir, 0);
    chk("R4 hdr10 plain", hdr10, 0);
    chk("R6 scl hold", scl_drive_low, 1);
    chk("R6 clock_hold", clock_hold, 1);
    chk("R5 ack drive", sda_drive_low, 1);
    clr_as();
    chk("R6 release", scl_drive_low, 0);
    bit_io(1'b1, s);
    chk("R5 ack seen", s, 0);
    chk("R5 ack released", sda_drive_low, 0);
    byte_out(8'h3C);
    tick(2);
    chk("R7 data_flag", data_flag, 1);
    chk("R7 no drive before clear", sda_drive_low, 0);
    chk("R6 data hold", scl_drive_low, 1);
    rsp_nack = 1'b0;
    clr_data();
    chk("R6 data release", scl_drive_low, 0);
    bit_io(1'b1, s);
    chk("R7 ack value", s, 0);
    byte_out(8'h11);
    rsp_nack = 1'b1;
    clr_data();
    bit_io(1'b1, s);
    chk("R7 nack value", s, 1);
    chk("R10 no collision on clean nack", collision, 0);
    bus_stop();
    tick(2);
    chk("R9 stop flag", as_flag, 1);
    chk("R9 stop cause", as_cause, 0);
    chk("R9 no hold on stop", scl_drive_low, 0);
    chk("R12 clean frame", bus_err, 0);
    clr_as();
    rsp_nack = 1'b0;
  endtask

  task automatic t_read();
    logic s;
    logic [7:0] v;
    set_addr(8'hA0);
    bus_start();
    byte_out(8'hA1);
    tick(2);
    chk("R1 dir read", dir, 1);
    clr_as();
    bit_io(1'b1, s);
    chk("R5 read ack", s, 0);
    tick(2);
    chk("R8 first data_flag", data_flag, 1);
    tx_byte = 8'hC5;
    clr_data();
    byte_in(v);
    chk("R8 byte C5", v, 8'hC5);
    bit_io(1'b0, s);
    tick(2);
    chk("R8 rx_ack ack", rx_ack, 0);
    chk("R8 next data_flag", data_flag, 1);
    tx_byte = 8'h5A;
    clr_data();
    byte_in(v);
    chk("R8 byte 5A", v, 8'h5A);
    bit_io(1'b1, s);
    tick(2);
    chk("R8 rx_ack nack", rx_ack, 1);
    chk("R8 nack ends", data_flag, 0);
    bus_stop();
    tick(2);
    chk("R9 stop after read", as_flag, 1);
    chk("R9 stop cause read", as_cause, 0);
    clr_as();
  endtask

  task automatic t_mismatch();
    logic s;
    set_addr(8'hA0);
    bus_start();
    byte_out(8'hA2);
    tick(2);
    chk("R2 no flag", as_flag, 0);
    chk("R2 no hold", scl_drive_low, 0);
    bit_io(1'b1, s);
    chk("R2 no ack", s, 1);
    byte_out(8'h00);
    bit_io(1'b1, s);
    chk("R2 ignored data ack", s, 1);
    chk("R2 no data flag", data_flag, 0);
    bus_stop();
    tick(2);
    chk("R9 unaddressed stop", as_flag, 0);
    chk("R12 no error", bus_err, 0);
  endtask

  task automatic t_gcall();
    logic s;
    set_addr(8'hA1);
    bus_start();
    byte_out(8'h00);
    tick(2);
    chk("R3 general call on", as_flag, 1);
    clr_as();
    bit_io(1'b1, s);
    chk("R3 general call ack", s, 0);
    bus_stop();
    tick(2);
    clr_as();
    set_addr(8'hA0);
    bus_start();
    byte_out(8'h00);
    tick(2);
    chk("R3 general call off", as_flag, 0);
    bit_io(1'b1, s);
    chk("R3 no ack when off", s, 1);
    bus_stop();
    tick(2);
  endtask

  task automatic t_hdr10();
    logic s;
    set_addr(8'hF4);
    bus_start();
    byte_out(8'hF4);
    tick(2);
    chk("R4 header match", as_flag, 1);
    chk("R4 hdr10 set", hdr10, 1);
    clr_as();
    bit_io(1'b1, s);
    chk("R4 header ack", s, 0);
    bus_stop();
    tick(2);
    clr_as();
    bus_start();
    byte_out(8'hF6);
    tick(2);
    chk("R4 other nn", as_flag, 0);
    bit_io(1'b1, s);
    bus_stop();
    tick(2);
  endtask

  task automatic t_buserr();
    logic s;
    set_addr(8'hA0);
    bus_start();
    for (int i = 0; i < 3; i++) bit_io(1'b1, s);
    bus_stop();
    tick(2);
    chk("R12 stop after 3 bits", bus_err, 1);
    clr_berr();
    chk("R12 cleared", bus_err, 0);
    bus_start();
    byte_out(8'hA2);
    bit_io(1'b1, s);
    bus_start();
    chk("R12 rstart after 9 bits", bus_err, 0);
    for (int i = 0; i < 5; i++) bit_io(1'b1, s);
    bus_start();
    chk("R12 rstart after 5 bits", bus_err, 1);
    clr_berr();
    bus_stop();
    tick(2);
    chk("R12 stop right after rstart", bus_err, 0);
  endtask

  task automatic t_coll();
    logic s;
    logic [6:0] rest;
    set_addr(8'hA0);
    bus_start();
    byte_out(8'hA1);
    clr_as();
    bit_io(1'b1, s);
    tx_byte = 8'h80;
    clr_data();
    bit_io(1'b0, s);
    tick(2);
    chk("R10 collision set", collision, 1);
    for (int i = 6; i >= 0; i--) begin
      bit_io(1'b1, s);
      rest[i] = s;
    end
    chk("R10 zeros not driven", rest, 7'h7F);
    chk("R10 sda off", sda_drive_low, 0);
    bit_io(1'b1, s);
    bus_start();
    chk("R11 cleared by rstart", collision, 0);
    byte_out(8'hA1);
    tick(2);
    chk("R11 match after rstart", as_flag, 1);
    clr_as();
    bit_io(1'b1, s);
    tx_byte = 8'hFF;
    clr_data();
    bit_io(1'b0, s);
    tick(2);
    chk("R10 second collision", collision, 1);
    clr_coll();
    chk("R11 cleared by write", collision, 0);
    for (int i = 0; i < 7; i++) bit_io(1'b1, s);
    bit_io(1'b1, s);
    bus_stop();
    tick(2);
    clr_as();
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(4);
    t_reset();
    t_write();
    t_read();
    t_mismatch();
    t_gcall();
    t_hdr10();
    t_buserr();
    t_coll();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule